// File: doc/BRIEF.md
# Serial Transmit Path with Clear-to-Send Pacing

This block is the sending half of an asynchronous serial port. The host pushes bytes into a 16-entry queue. A serializer takes them one at a time and drives them onto a single line as framed characters: a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or more high stop bits. Every bit lasts 16 pulses of a 16x baud enable that comes from outside the block.

When pacing is switched on, a low clear-to-send input stops the next character from starting. A character that is already on the line always finishes. The block raises a transmit interrupt when the queue drains to a selected level, and it does so only after the host has refilled the queue by a margin. A DMA-style ready line tells the host whether a write will be accepted. The host can also hold the line low to send a break.

Top module: `txpath_cts`

## Requirements
- R1: A character is sent as a 0 start bit, then `cfg_wlen`+5 data bits least significant first (`cfg_wlen` 0 gives 5 bits, 3 gives 8), then a parity bit when `cfg_par_en` is 1, then a stop level of 1. The parity bit is chosen so that the number of ones in the data and parity together is even when `cfg_par_even` is 1 and odd when it is 0. Each bit lasts 16 cycles in which `tick16` is high.
- R2: The stop level lasts 16 ticks when `cfg_long_stop` is 0. When it is 1, the stop level lasts 24 ticks for 5-bit characters and 32 ticks for all other lengths. `tx_idle` rises exactly when the stop level ends.
- R3: Characters leave in the order they were written. The queue holds 16 characters when `cfg_fifo_en` is 1 and one character when it is 0. A write made while the queue is at capacity is discarded, even if the serializer takes a character in that same cycle.
- R4: `txrdy` is 1 while the queue is below capacity: below 16 entries in queued mode, and empty in single-character mode.
- R5: While `cfg_auto_cts` is 1 and `cts_ok` is 0, no new start bit begins. A character already being sent is completed in full, and sending resumes once `cts_ok` returns to 1.
- R6: While `cfg_auto_cts` is 0, the level of `cts_ok` has no effect on sending.
- R7: While `cfg_break` is 1, `txd` is 0 from the next cycle onward. After `cfg_break` is released, an idle line returns to 1.
- R8: After reset, `txd` is 1, `txrdy` is 1, `tx_level` is 0, `tx_irq` is 0, and `thr_empty` and `tx_idle` are 1. `thr_empty` is 1 exactly when the queue is empty. `tx_idle` is 1 when the queue is empty and no character is being sent.
- R9: When `cfg_thre_ie` is 1, `tx_irq` rises once the queue level falls to the threshold. The threshold is `cfg_trig_sel`×4 in queued mode and 0 in single-character mode. The interrupt fires only if the level has reached at least threshold+2 (queued mode) or threshold+1 (single-character mode) since the last time it fired. With `cfg_thre_ie` at 0, no interrupt is raised.
- R10: An accepted write or an `iid_read` pulse clears `tx_irq` on the next cycle. A clear takes priority over a raise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| iid_read | input | 1 | Host read of interrupt identity; clears the transmit interrupt |
| tick16 | input | 1 | 16x baud enable |
| cts_ok | input | 1 | Clear-to-send, 1 = remote side ready |
| cfg_fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding slot |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Insert parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_long_stop | input | 1 | Long stop (1.5 or 2 bits) |
| cfg_break | input | 1 | Force line low |
| cfg_auto_cts | input | 1 | Enable clear-to-send pacing |
| cfg_thre_ie | input | 1 | Transmit interrupt enable |
| cfg_trig_sel | input | 2 | Interrupt threshold select |
| txd | output | 1 | Serial output |
| tx_irq | output | 1 | Transmit interrupt request |
| txrdy | output | 1 | DMA ready: a write will be accepted |
| thr_empty | output | 1 | Queue empty |
| tx_idle | output | 1 | Queue and serializer both empty |
| tx_level | output | 5 | Queue occupancy |

## Verification
The serializer can take the head of a full queue in the same cycle that the host writes a new byte. The bench provokes this by filling the queue while clear-to-send is held low, then releasing it while a write strobe with a changing byte is held high for many cycles. The write that coincides with the take must be dropped and the write one cycle later must be kept, so the 17th character on the line has to be exactly the second byte of that burst and no 18th character may follow. The bench also removes clear-to-send in the middle of a character and checks that the frame still completes intact.

// File: rtl/txpath_pkg.sv
package txpath_pkg;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_START,
    SH_DATA,
    SH_PAR,
    SH_STOP
  } sh_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       long_stop;
  } frame_cfg_t;

  // keeps the low (wlen+5) bits of a byte
  function automatic logic [7:0] data_mask(input logic [1:0] wlen);
    return 8'(8'hFF >> (2'd3 - wlen));
  endfunction

endpackage

// File: rtl/txpath_fifo.sv
module txpath_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= AW'(wp_q + AW'(1));
      if (pop)  rp_q <= AW'(rp_q + AW'(1));
      cnt_q <= CW'(cnt_q + CW'(push) - CW'(pop));
    end
  end

  assign dout  = mem[rp_q];
  assign level = cnt_q;

endmodule

// File: rtl/txpath_shifter.sv
module txpath_shifter import txpath_pkg::*; #(
  parameter int TICKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       go,
  input  logic       brk,
  input  frame_cfg_t cfg,
  input  logic [7:0] din,
  output logic       take,
  output logic       busy,
  output logic       txd
);
  localparam int LONG = 2 * TICKS;
  localparam int HALF = TICKS + TICKS / 2;
  localparam int TCW  = $clog2(LONG + 1);

  sh_state_e     st_q, st_n;
  logic [TCW-1:0] cnt_q, cnt_n, stop_last, bit_last;
  logic [2:0]    idx_q, idx_n, idx_last;
  logic [7:0]    sr_q, sr_n, masked;
  logic          par_q, par_n, bit_n, bit_end;
  frame_cfg_t    cfg_q, cfg_n;

  always_comb begin
    if (!cfg_q.long_stop)       stop_last = TCW'(TICKS - 1);
    else if (cfg_q.wlen == 2'd0) stop_last = TCW'(HALF - 1);
    else                        stop_last = TCW'(LONG - 1);
    bit_last = (st_q == SH_STOP) ? stop_last : TCW'(TICKS - 1);
    bit_end  = tick && (cnt_q == bit_last);
    idx_last = 3'(cfg_q.wlen) + 3'd4;
    masked   = din & data_mask(cfg.wlen);
  end

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    idx_n = idx_q;
    sr_n  = sr_q;
    par_n = par_q;
    cfg_n = cfg_q;
    take  = 1'b0;
    if (st_q == SH_IDLE) begin
      if (go) begin
        take  = 1'b1;
        st_n  = SH_START;
        cnt_n = '0;
        idx_n = '0;
        sr_n  = masked;
        cfg_n = cfg;
        par_n = cfg.par_even ? ^masked : ~^masked;
      end
    end else if (bit_end) begin
      cnt_n = '0;
      case (st_q)
        SH_START: st_n = SH_DATA;
        SH_DATA: begin
          if (idx_q == idx_last) begin
            st_n = cfg_q.par_en ? SH_PAR : SH_STOP;
          end else begin
            sr_n  = sr_q >> 1;
            idx_n = idx_q + 3'd1;
          end
        end
        SH_PAR:  st_n = SH_STOP;
        default: st_n = SH_IDLE;
      endcase
    end else if (tick) begin
      cnt_n = TCW'(cnt_q + TCW'(1));
    end

    case (st_n)
      SH_START: bit_n = 1'b0;
      SH_DATA:  bit_n = sr_n[0];
      SH_PAR:   bit_n = par_n;
      default:  bit_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sr_q  <= '0;
      par_q <= 1'b0;
      cfg_q <= '0;
      txd   <= 1'b1;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      sr_q  <= sr_n;
      par_q <= par_n;
      cfg_q <= cfg_n;
      txd   <= brk ? 1'b0 : bit_n;
    end
  end

  assign busy = (st_q != SH_IDLE);

endmodule

// File: rtl/txpath_irq.sv
module txpath_irq #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic                       fifo_en,
  input  logic [1:0]                 trig_sel,
  input  logic                       ie,
  input  logic                       clr,
  output logic                       irq
);
  localparam int CW   = $clog2(DEPTH+1);
  localparam int STEP = DEPTH / 4;

  logic [CW-1:0] thr, arm_lvl;
  logic          armed_q, irq_q, evt;

  always_comb begin
    thr     = fifo_en ? CW'(CW'(trig_sel) * CW'(STEP)) : '0;
    arm_lvl = CW'(thr + (fifo_en ? CW'(2) : CW'(1)));
    evt     = armed_q && (level <= thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (evt)                 armed_q <= 1'b0;
      else if (level >= arm_lvl) armed_q <= 1'b1;
      if (clr)                 irq_q <= 1'b0;
      else if (evt && ie)      irq_q <= 1'b1;
    end
  end

  assign irq = irq_q & ie;

endmodule

// File: rtl/txpath_cts.sv
module txpath_cts import txpath_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int TICKS = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  input  logic                       iid_read,
  input  logic                       tick16,
  input  logic                       cts_ok,
  input  logic                       cfg_fifo_en,
  input  logic [1:0]                 cfg_wlen,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_even,
  input  logic                       cfg_long_stop,
  input  logic                       cfg_break,
  input  logic                       cfg_auto_cts,
  input  logic                       cfg_thre_ie,
  input  logic [1:0]                 cfg_trig_sel,
  output logic                       txd,
  output logic                       tx_irq,
  output logic                       txrdy,
  output logic                       thr_empty,
  output logic                       tx_idle,
  output logic [$clog2(DEPTH+1)-1:0] tx_level
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] level, cap;
  logic [7:0]    head;
  logic          wr_ok, go, take, sh_busy;
  frame_cfg_t    fcfg;

  assign fcfg = '{wlen: cfg_wlen, par_en: cfg_par_en, par_even: cfg_par_even,
                  long_stop: cfg_long_stop};

  assign cap   = cfg_fifo_en ? CW'(DEPTH) : CW'(1);
  assign wr_ok = wr_en && (level < cap);
  assign go    = (level != '0) && (!cfg_auto_cts || cts_ok);

  txpath_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst(rst), .push(wr_ok), .din(wr_data),
    .pop(take), .dout(head), .level(level)
  );

  txpath_shifter #(.TICKS(TICKS)) u_shift (
    .clk(clk), .rst(rst), .tick(tick16), .go(go), .brk(cfg_break),
    .cfg(fcfg), .din(head), .take(take), .busy(sh_busy), .txd(txd)
  );

  txpath_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .level(level), .fifo_en(cfg_fifo_en),
    .trig_sel(cfg_trig_sel), .ie(cfg_thre_ie), .clr(wr_ok | iid_read),
    .irq(tx_irq)
  );

  assign txrdy     = (level < cap);
  assign thr_empty = (level == '0);
  assign tx_idle   = (level == '0) && !sh_busy;
  assign tx_level  = level;

endmodule

// File: rtl/txpath_cts_chk.sv
module txpath_cts_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_ok,
  input logic                       iid_read,
  input logic                       cfg_break,
  input logic                       cfg_auto_cts,
  input logic                       cts_ok,
  input logic                       sh_busy,
  input logic                       txd,
  input logic                       tx_irq,
  input logic [$clog2(DEPTH+1)-1:0] tx_level
);
  localparam int CW = $clog2(DEPTH+1);

  a_r3_level_cap: assert property (@(posedge clk) disable iff (rst)
    32'(tx_level) <= DEPTH);

  a_r3_level_step: assert property (@(posedge clk) disable iff (rst)
    {1'b0, tx_level} <= (CW+1)'({1'b0, $past(tx_level)} + (CW+1)'(1)));

  a_r5_cts_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_auto_cts && !cts_ok && !sh_busy) |=> !sh_busy);

  a_r7_break_low: assert property (@(posedge clk) disable iff (rst)
    cfg_break |=> !txd);

  a_r8_idle_mark: assert property (@(posedge clk) disable iff (rst)
    (!sh_busy && !$past(cfg_break)) |-> txd);

  a_r10_irq_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_ok || iid_read) |=> !tx_irq);

endmodule

bind txpath_cts txpath_cts_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_ok(wr_ok), .iid_read(iid_read),
  .cfg_break(cfg_break), .cfg_auto_cts(cfg_auto_cts), .cts_ok(cts_ok),
  .sh_busy(sh_busy), .txd(txd), .tx_irq(tx_irq), .tx_level(tx_level)
);

// File: tb/txpath_cts_test.sv
`timescale 1ns/1ps
module txpath_cts_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, iid_read = 1'b0, tick16 = 1'b1, cts_ok = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic cfg_fifo_en = 1'b1, cfg_par_en = 1'b0, cfg_par_even = 1'b0;
  logic cfg_long_stop = 1'b0, cfg_break = 1'b0, cfg_auto_cts = 1'b0, cfg_thre_ie = 1'b0;
  logic [1:0] cfg_wlen = 2'd3, cfg_trig_sel = 2'd0;
  logic txd, tx_irq, txrdy, thr_empty, tx_idle;
  logic [4:0] tx_level;
  int n_chk = 0, n_err = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txpath_cts uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .iid_read(iid_read),
    .tick16(tick16), .cts_ok(cts_ok), .cfg_fifo_en(cfg_fifo_en), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_long_stop(cfg_long_stop),
    .cfg_break(cfg_break), .cfg_auto_cts(cfg_auto_cts), .cfg_thre_ie(cfg_thre_ie),
    .cfg_trig_sel(cfg_trig_sel), .txd(txd), .tx_irq(tx_irq), .txrdy(txrdy),
    .thr_empty(thr_empty), .tx_idle(tx_idle), .tx_level(tx_level)
  );

  // {wlen, par_en, par_even, long_stop, data}
  localparam logic [12:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'h55},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'hA7},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h3C},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'h1B},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'hF6},
    {2'd1, 1'b1, 1'b1, 1'b1, 8'h2D},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'h7F},
    {2'd2, 1'b1, 1'b1, 1'b0, 8'hC3}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_iid();
    @(negedge clk);
    iid_read = 1'b1;
    @(negedge clk);
    iid_read = 1'b0;
  endtask

  task automatic rx_char(output logic [7:0] d, output logic p, output logic stop_ok,
                         output int t0);
    int nb = int'(cfg_wlen) + 5;
    int guard = 0;
    d = 8'h00;
    p = 1'b0;
    stop_ok = 1'b0;
    while (txd !== 1'b0 && guard < 6000) begin
      @(negedge clk);
      guard++;
    end
    t0 = cyc;
    if (guard >= 6000) chk("R1", "start bit seen", 32'd0, 32'd1);
    repeat (8) @(negedge clk);
    chk("R1", "start bit level", 32'(txd), 32'd0);
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
    end
    if (cfg_par_en) begin
      repeat (16) @(negedge clk);
      p = txd;
    end
    repeat (16) @(negedge clk);
    stop_ok = txd;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (tx_idle !== 1'b1 && guard < 6000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 6000) chk("R8", "idle reached", 32'd0, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d, m, dexp;
    logic p, so;
    int t0, nb, stp, dur, lows;
    logic [7:0] got [17];

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8", "txd after reset", 32'(txd), 32'd1);
    chk("R4", "txrdy after reset", 32'(txrdy), 32'd1);
    chk("R8", "level after reset", 32'(tx_level), 32'd0);
    chk("R8", "irq after reset", 32'(tx_irq), 32'd0);
    chk("R8", "thr_empty after reset", 32'(thr_empty), 32'd1);
    chk("R8", "tx_idle after reset", 32'(tx_idle), 32'd1);

    // R1 / R2 frame vectors
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      cfg_wlen      = VEC[v][12:11];
      cfg_par_en    = VEC[v][10];
      cfg_par_even  = VEC[v][9];
      cfg_long_stop = VEC[v][8];
      nb = int'(VEC[v][12:11]) + 5;
      m  = 8'((9'd1 << nb) - 9'd1);
      dexp = VEC[v][7:0] & m;
      put(VEC[v][7:0]);
      rx_char(d, p, so, t0);
      chk("R1", "data bits", 32'(d), 32'(dexp));
      if (VEC[v][10]) chk("R1", "parity bit", 32'(p), 32'(VEC[v][9] ? ^dexp : ~^dexp));
      chk("R1", "stop level", 32'(so), 32'd1);
      wait_idle();
      dur  = cyc - t0;
      stp  = !VEC[v][8] ? 16 : (nb == 5 ? 24 : 32);
      chk("R2", "frame length", 32'(dur), 32'(16 * (1 + nb + int'(VEC[v][10])) + stp));
    end
    @(negedge clk);
    cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_long_stop = 1'b0;

    // R7 break
    @(negedge clk);
    cfg_break = 1'b1;
    @(negedge clk);
    chk("R7", "break forces low", 32'(txd), 32'd0);
    repeat (5) @(negedge clk);
    chk("R7", "break held low", 32'(txd), 32'd0);
    cfg_break = 1'b0;
    @(negedge clk);
    chk("R7", "release returns high", 32'(txd), 32'd1);

    // R5 hold while not clear to send
    cfg_auto_cts = 1'b1;
    cts_ok = 1'b0;
    put(8'h11);
    lows = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R5", "no start while held", 32'(lows), 32'd0);
    chk("R5", "character waits in queue", 32'(tx_level), 32'd1);
    chk("R8", "not idle with queued byte", 32'(tx_idle), 32'd0);
    chk("R8", "thr_empty with queued byte", 32'(thr_empty), 32'd0);
    cts_ok = 1'b1;
    rx_char(d, p, so, t0);
    chk("R5", "resumed character", 32'(d), 32'h11);
    wait_idle();

    // R5 loss mid-character
    @(negedge clk);
    cts_ok = 1'b0;
    put(8'h21);
    put(8'h22);
    fork
      rx_char(d, p, so, t0);
      begin
        cts_ok = 1'b1;
        repeat (60) @(negedge clk);
        cts_ok = 1'b0;
      end
    join
    chk("R5", "character completes after loss", 32'(d), 32'h21);
    chk("R5", "stop of cut character", 32'(so), 32'd1);
    lows = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R5", "next start held back", 32'(lows), 32'd0);
    chk("R5", "second byte still queued", 32'(tx_level), 32'd1);
    cts_ok = 1'b1;
    rx_char(d, p, so, t0);
    chk("R5", "second byte after resume", 32'(d), 32'h22);
    wait_idle();

    // R6 pacing disabled
    @(negedge clk);
    cfg_auto_cts = 1'b0;
    cts_ok = 1'b0;
    put(8'h5A);
    rx_char(d, p, so, t0);
    chk("R6", "sent despite cts low", 32'(d), 32'h5A);
    wait_idle();
    cts_ok = 1'b1;

    // R3 / R4 full queue
    cfg_auto_cts = 1'b1;
    cts_ok = 1'b0;
    for (int i = 0; i < 16; i++) put(8'(i * 7 + 1));
    @(negedge clk);
    chk("R4", "txrdy low when full", 32'(txrdy), 32'd0);
    chk("R3", "level at capacity", 32'(tx_level), 32'd16);
    put(8'hEE);
    put(8'hEF);
    @(negedge clk);
    chk("R3", "write to full ignored", 32'(tx_level), 32'd16);
    cts_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rx_char(d, p, so, t0);
      chk("R3", "order preserved", 32'(d), 32'(8'(i * 7 + 1)));
      if (i == 0) chk("R4", "txrdy back after take", 32'(txrdy), 32'd1);
    end
    wait_idle();
    chk("R3", "nothing extra queued", 32'(tx_level), 32'd0);

    // R3 write to full in the cycle of a take
    cts_ok = 1'b0;
    for (int i = 0; i < 16; i++) put(8'(8'h40 + i));
    @(negedge clk);
    cts_ok = 1'b1;
    fork
      for (int i = 0; i < 17; i++) begin
        rx_char(d, p, so, t0);
        got[i] = d;
      end
      begin
        for (int k = 0; k < 40; k++) begin
          wr_en = 1'b1;
          wr_data = 8'(8'h80 + k);
          @(negedge clk);
        end
        wr_en = 1'b0;
      end
    join
    for (int i = 0; i < 16; i++) chk("R3", "burst order", 32'(got[i]), 32'(8'(8'h40 + i)));
    chk("R3", "only the write after the take lands", 32'(got[16]), 32'h81);
    wait_idle();
    chk("R3", "no further byte", 32'(tx_level), 32'd0);

    // R3 / R4 single-character mode
    @(negedge clk);
    cfg_fifo_en = 1'b0;
    cts_ok = 1'b0;
    @(negedge clk);
    chk("R4", "txrdy when slot empty", 32'(txrdy), 32'd1);
    put(8'h33);
    @(negedge clk);
    chk("R4", "txrdy low when slot full", 32'(txrdy), 32'd0);
    put(8'h44);
    @(negedge clk);
    chk("R3", "second write to slot ignored", 32'(tx_level), 32'd1);
    cts_ok = 1'b1;
    rx_char(d, p, so, t0);
    chk("R3", "slot byte sent", 32'(d), 32'h33);
    wait_idle();
    chk("R3", "ignored byte absent", 32'(tx_level), 32'd0);
    chk("R4", "txrdy after drain", 32'(txrdy), 32'd1);
    cfg_fifo_en = 1'b1;

    // R9 hysteresis: one byte does not arm
    cfg_thre_ie = 1'b1;
    cfg_trig_sel = 2'd0;
    put(8'h01);
    wait_idle();
    chk("R9", "single byte does not arm", 32'(tx_irq), 32'd0);
    // R9 two bytes arm, drain raises
    cts_ok = 1'b0;
    put(8'h02);
    put(8'h03);
    cts_ok = 1'b1;
    rx_char(d, p, so, t0);
    rx_char(d, p, so, t0);
    wait_idle();
    chk("R9", "empty raises irq", 32'(tx_irq), 32'd1);
    pulse_iid();
    chk("R10", "identity read clears", 32'(tx_irq), 32'd0);

    // R10 write clears
    cts_ok = 1'b0;
    put(8'h04);
    put(8'h05);
    cts_ok = 1'b1;
    rx_char(d, p, so, t0);
    lows = 0;
    while (tx_irq !== 1'b1 && lows < 400) begin
      @(negedge clk);
      lows++;
    end
    chk("R9", "irq on drain", 32'(tx_irq), 32'd1);
    put(8'h77);
    chk("R10", "write clears", 32'(tx_irq), 32'd0);
    rx_char(d, p, so, t0);
    rx_char(d, p, so, t0);
    chk("R3", "refill byte sent", 32'(d), 32'h77);
    wait_idle();
    chk("R9", "no re-arm from one byte", 32'(tx_irq), 32'd0);

    // R9 threshold 4
    cfg_trig_sel = 2'd1;
    cts_ok = 1'b0;
    for (int i = 0; i < 8; i++) put(8'(8'hA0 + i));
    cts_ok = 1'b1;
    fork
      for (int i = 0; i < 8; i++) rx_char(d, p, so, t0);
      begin
        lows = 0;
        while (tx_irq !== 1'b1 && lows < 3000) begin
          @(negedge clk);
          lows++;
        end
        chk("R9", "level at threshold rise", 32'(tx_level), 32'd4);
      end
    join
    wait_idle();
    pulse_iid();
    cfg_trig_sel = 2'd0;

    // R9 disabled interrupt
    cfg_thre_ie = 1'b0;
    cts_ok = 1'b0;
    put(8'h06);
    put(8'h07);
    cts_ok = 1'b1;
    rx_char(d, p, so, t0);
    rx_char(d, p, so, t0);
    wait_idle();
    chk("R9", "no irq when disabled", 32'(tx_irq), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule